// File: doc/BRIEF.md
# HDLC Frame Status Queue

This block sits next to a bit-oriented serial receiver and keeps a small queue of per-frame status words. The receiver supplies a strobe each time it detects a flag sequence, a strobe for each data byte it assembles, and a few status bits for the frame that is ending, such as a CRC error and the residue code. The block counts the bytes between flags. When a flag closes a frame, it writes the byte count and the status bits into the queue as one entry.

The flags themselves mark the frame boundaries. A flag that follows at least one byte closes the frame, commits its entry and restarts the count. The same flag also opens the next frame. Software therefore does not need to act between frames and can let up to ten completed frames build up before it services the receiver. Software removes entries one at a time with a read strobe and sees the oldest entry at the head output.

Top module: `hdlc_fsf`

## Requirements
- R1: After reset, and while `en_i` is low, `empty_o` is 1, `full_o` is 0 and `count_o` is 0. After reset `ovf_o` is 0.
- R2: After `en_i` rises, byte strobes are ignored until the first flag strobe arrives.
- R3: A flag strobe that arrives when no byte has been counted since the previous flag (or since the first flag after enable) writes no entry and leaves `count_o` unchanged.
- R4: A flag strobe that follows one or more counted bytes commits one entry. The entry holds the byte count in bits [13:0] and `stat_i` (sampled in the flag cycle) in bits [18:14]. The count then restarts from zero, so frames that share a flag each get their own entry.
- R5: The queue holds 10 entries. `count_o` gives the number of stored entries, and `full_o` is 1 when 10 entries are stored.
- R6: A closing flag that arrives while the queue is full, with no read in the same cycle, drops its entry. It also sets `ovf_o`, which stays at 1 until an `ovf_clr_i` pulse.
- R7: A read strobe removes the head entry when the queue is not empty and has no effect when it is empty. A read and a commit in the same cycle leave `count_o` unchanged, and the commit is accepted even when the queue is full.
- R8: Entries leave the queue in the order they were committed. `head_o` stays stable while no read occurs.
- R9: While `en_i` is low, the queue is emptied and the byte counter is cleared. Strobes write nothing, and `ovf_o` keeps its value.
- R10: A byte strobe in the same cycle as a flag strobe is ignored.
- R11: The byte count saturates at 16383.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Enable; when low the queue and counter are held cleared |
| flag_i | input | 1 | Flag-detected strobe |
| byte_i | input | 1 | Received-byte strobe |
| stat_i | input | 5 | Frame status bits, sampled on the closing flag |
| rd_i | input | 1 | Read strobe, pops the head entry |
| ovf_clr_i | input | 1 | Clears the sticky overflow bit |
| head_o | output | 19 | Oldest entry: {status, byte count} |
| empty_o | output | 1 | Queue holds no entries |
| full_o | output | 1 | Queue holds 10 entries |
| count_o | output | 4 | Number of stored entries |
| ovf_o | output | 1 | Sticky: a frame was dropped because the queue was full |

## Verification
A byte counter that does not restart at a flag shows up in the next entry read out: its count field includes bytes from the frame before. A broken open/close decision shows up as an extra or missing entry as soon as `count_o` is sampled, one cycle after the flag. Pointer or occupancy faults change the order or number of entries. The scoreboard detects these on the next read and on the final drain, when the queue does not empty on time. Overflow faults appear at `ovf_o` one cycle after the eleventh closing flag.

// File: rtl/hdlc_fsf.sv
module hdlc_fsf #(
  parameter int DEPTH  = 10,
  parameter int CNT_W  = 14,
  parameter int STAT_W = 5,
  localparam int ENT_W = CNT_W + STAT_W,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              flag_i,
  input  logic              byte_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              rd_i,
  input  logic              ovf_clr_i,
  output logic [ENT_W-1:0]  head_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [OCC_W-1:0]  count_o,
  output logic              ovf_o
);
  localparam logic [CNT_W-1:0] BC_MAX = '1;
  localparam logic [PTR_W-1:0] LAST   = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] FULLV  = OCC_W'(DEPTH);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [OCC_W-1:0] occ;
  logic [CNT_W-1:0] bc;
  logic             in_frame;

  wire pop   = en_i && rd_i && (occ != '0);
  wire close = en_i && flag_i && in_frame && (bc != '0);
  wire push  = close && ((occ != FULLV) || pop);
  wire drop  = close && !push;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      wp <= '0;
      rp <= '0;
      occ <= '0;
      bc <= '0;
      in_frame <= 1'b0;
    end else begin
      if (flag_i) begin
        bc <= '0;
        in_frame <= 1'b1;
      end else if (byte_i && in_frame && bc != BC_MAX) begin
        bc <= bc + 1'b1;
      end
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      if (push && !pop)      occ <= occ + 1'b1;
      else if (pop && !push) occ <= occ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {stat_i, bc};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         ovf_o <= 1'b0;
    else if (drop)      ovf_o <= 1'b1;
    else if (ovf_clr_i) ovf_o <= 1'b0;
  end

  assign head_o  = mem[rp];
  assign count_o = occ;
  assign empty_o = (occ == '0);
  assign full_o  = (occ == FULLV);
endmodule

module hdlc_fsf_chk #(
  parameter int DEPTH = 10,
  parameter int ENT_W = 19,
  parameter int OCC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             flag_i,
  input logic             rd_i,
  input logic             ovf_clr_i,
  input logic [ENT_W-1:0] head_o,
  input logic             empty_o,
  input logic             full_o,
  input logic [OCC_W-1:0] count_o,
  input logic             ovf_o
);
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= OCC_W'(DEPTH)); // R5
  AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && full_o && !rd_i |=> full_o); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !ovf_clr_i |=> ovf_o); // R6
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && rd_i && !empty_o && !flag_i |=> count_o == $past(count_o) - 1'b1); // R7
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !rd_i && !empty_o |=> $stable(head_o)); // R8
  AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> empty_o && !full_o); // R9
endmodule

bind hdlc_fsf hdlc_fsf_chk #(.DEPTH(DEPTH), .ENT_W(ENT_W), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .flag_i(flag_i), .rd_i(rd_i),
  .ovf_clr_i(ovf_clr_i), .head_o(head_o), .empty_o(empty_o), .full_o(full_o),
  .count_o(count_o), .ovf_o(ovf_o)
);

// File: tb/tb_hdlc_fsf.sv
module tb_hdlc_fsf;
  localparam int DEPTH = 10;
  localparam int BCMAX = 16383;

  logic clk = 0, rst_n = 0, en_i = 0, flag_i = 0, byte_i = 0, rd_i = 0, ovf_clr_i = 0;
  logic [4:0]  stat_i = '0;
  logic [18:0] head_o;
  logic        empty_o, full_o, ovf_o;
  logic [3:0]  count_o;

  hdlc_fsf dut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [18:0] exp_q[$];
  int  m_bc = 0;
  bit  m_inf = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, pushes expected entries
  task automatic cyc(input bit f, input bit b, input bit r, input logic [4:0] s);
    bit popm;
    @(posedge clk); #2;
    flag_i = f; byte_i = b; rd_i = r; stat_i = s;
    if (en_i) begin
      popm = r && exp_q.size() > 0;
      if (f) begin
        if (m_inf && m_bc > 0) begin
          if (exp_q.size() < DEPTH || popm) exp_q.push_back({s, 14'(m_bc)});
        end
        m_bc = 0; m_inf = 1;
      end else if (b && m_inf && m_bc < BCMAX) m_bc++;
    end
  endtask

  task automatic idle(); cyc(0, 0, 0, 5'h0); endtask

  task automatic bytes(input int n);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, 5'h0);
  endtask

  task automatic set_en(input bit v);
    @(posedge clk); #2;
    en_i = v; flag_i = 0; byte_i = 0; rd_i = 0;
    if (!v) exp_q.delete();
    m_bc = 0; m_inf = 0;
  endtask

  task automatic drain(input string tag);
    while (exp_q.size() > 0) cyc(0, 0, 1, 5'h0);
    idle();
    @(negedge clk);
    chk(empty_o === 1'b1 && count_o === 4'd0, tag, count_o, 0);
  endtask

  task automatic look(input string tag, input int exp_cnt);
    idle();
    @(negedge clk);
    chk(count_o === 4'(exp_cnt), tag, count_o, exp_cnt);
  endtask

  // monitor: compares head entry against scoreboard on every pop
  always @(negedge clk) begin
    if (rst_n && en_i && rd_i && !empty_o) begin
      if (exp_q.size() == 0) chk(0, "R8 unexpected entry", head_o, 0);
      else begin
        automatic logic [18:0] e = exp_q.pop_front();
        chk(head_o === e, "R4/R8 head entry", head_o, e);
      end
    end
  end

  initial begin
    #(20 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    idle();
    @(negedge clk);
    chk(empty_o === 1 && full_o === 0 && count_o === 0 && ovf_o === 0, "R1 reset state",
        {empty_o, full_o, count_o, ovf_o}, 7'b1000000);
    set_en(1);

    // R2: bytes before first flag ignored
    bytes(3); cyc(1, 0, 0, 5'h0); bytes(2); cyc(1, 0, 0, 5'h03);
    look("R2 one entry", 1);
    drain("R2 drain");

    // R3: flags without bytes write nothing
    cyc(1, 0, 0, 5'h1); cyc(1, 0, 0, 5'h2); cyc(1, 0, 0, 5'h3);
    look("R3 no entry", 0);

    // R4: back-to-back frames sharing a flag
    bytes(4); cyc(1, 0, 0, 5'h01); bytes(5); cyc(1, 0, 0, 5'h1e);
    look("R4 two entries", 2);
    drain("R4 drain");

    // R5/R6: fill, then overflow
    for (int k = 1; k <= DEPTH; k++) begin bytes(k); cyc(1, 0, 0, 5'(k)); end
    idle(); @(negedge clk);
    chk(full_o === 1 && count_o === 4'd10, "R5 full at 10", count_o, 10);
    chk(ovf_o === 0, "R6 no overflow yet", ovf_o, 0);
    bytes(7); cyc(1, 0, 0, 5'h1f);
    idle(); @(negedge clk);
    chk(ovf_o === 1 && count_o === 4'd10, "R6 overflow dropped", {ovf_o, count_o}, 5'h1a);
    drain("R6 drain keeps order");
    chk(ovf_o === 1, "R6 sticky", ovf_o, 1);
    @(posedge clk); #2 ovf_clr_i = 1;
    @(posedge clk); #2 ovf_clr_i = 0;
    @(negedge clk);
    chk(ovf_o === 0, "R6 cleared", ovf_o, 0);

    // R7: read on empty has no effect
    cyc(0, 0, 1, 5'h0);
    look("R7 read empty", 0);

    // R7: read and commit in the same cycle while full
    for (int k = 1; k <= DEPTH; k++) begin bytes(2); cyc(1, 0, 0, 5'(k)); end
    bytes(3); cyc(1, 0, 1, 5'h15);
    idle(); @(negedge clk);
    chk(count_o === 4'd10 && ovf_o === 0, "R7 rd+wr full", {ovf_o, count_o}, 5'h0a);
    drain("R7 drain");

    // R10: byte in flag cycle ignored
    bytes(2); cyc(1, 1, 0, 5'h0a); bytes(1); cyc(1, 0, 0, 5'h0b);
    look("R10 entries", 2);
    drain("R10 drain");

    // R9: disable clears and blocks writes
    bytes(2); cyc(1, 0, 0, 5'h04); bytes(1); cyc(1, 0, 0, 5'h05);
    look("R9 before disable", 2);
    @(posedge clk); #2 ovf_clr_i = 0;
    set_en(0);
    cyc(1, 0, 0, 5'h0); cyc(0, 1, 0, 5'h0); cyc(1, 0, 0, 5'h1);
    idle(); @(negedge clk);
    chk(empty_o === 1 && count_o === 0, "R9 disabled empty", count_o, 0);
    set_en(1);
    bytes(2); cyc(1, 0, 0, 5'h0); bytes(1); cyc(1, 0, 0, 5'h06);
    look("R9 after reenable", 1);
    drain("R9 drain");

    // R11: saturation
    bytes(BCMAX + 20); cyc(1, 0, 0, 5'h11);
    look("R11 saturated entry", 1);
    drain("R11 drain");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule